// File: doc/BRIEF.md
# Keypad Controller Command Register Interface

This block turns a byte-oriented host transaction stream into register accesses for a keypad controller. A front end (for example a serial two-wire target) delivers a start strobe with a direction flag, then a sequence of written bytes or read requests. In a write transaction the first byte picks a command and every later byte is a parameter for it, numbered by its position. In a read transaction each request returns one byte of command-specific data, chosen by the byte's position.

The block keeps the configuration byte, the clock setup, the active time, the debounce time, the keypad geometry and three 16-bit GPIO setup words. All of them are outputs, for the scanner and the pin logic. It also keeps an interrupt-status byte and a sticky error byte. When any status bit is set, it pulls an active-low interrupt line. The key event FIFO sits in a neighbouring block. This block reaches it through a level input, an index/data peek port, a pop strobe and a flush strobe.

Once a command has taken its last parameter, the block parks the command register on an idle code. A stray extra byte is then reported as a bad parameter and does not corrupt a register.

Top module: `kpc_cmd_regs`

## Requirements
- R1: After hardware reset: configuration 0x80, status 0x10, active time 125, debounce 3, keypad size 0x33, clock 0x08, the three GPIO words 0, error 0. Error bits are only ever set, never cleared, until the next hardware reset.
- R2: A start strobe zeroes the byte index and latches the direction (1 = write). Each accepted byte advances the index, which saturates at its maximum. The write byte at index 0 loads the command. Write bytes in a read transaction and read requests in a write transaction are ignored.
- R3: `irq_n` is low exactly when the status byte is nonzero, one cycle after the status changes.
- R4: A command that takes its last parameter sets the command register to 0xFF. A parameter byte written while the command is 0xFF sets bad-parameter (error bit 0).
- R5: Reading status (0x82) returns the status byte at index 0. The read clears status to zero only when the not-initialised bit (bit 4) is clear.
- R6: Reads return, low byte first where 16-bit:
  - 0x80: 0x0400.
  - 0x92: configuration AND 0x0F.
  - 0x94: (clock AND 0xFC) OR 0x02.
  - 0x91: keypad size.
  - 0x8C: error byte.
  - 0x8E: 0.
  - Any index past a value's width reads 0.
- R7: Command 0x83 with parameter 0xAA restores the R1 values of configuration, status, active time, debounce, keypad size and clock. It leaves error and the GPIO words unchanged. Any other parameter sets bad-parameter.
- R8: These commands always store their parameter:
  - 0x90 (keypad size) sets bad-parameter if bits 3:0 are outside 3..12 or bits 7:4 are outside 3..8.
  - 0x8F (debounce) sets bad-parameter on 0.
  - 0x93 (clock) sets bad-parameter when bits 1:0 are 01 or 10.
  - 0x8B sets the active time.
- R9: Commands 0x84, 0x85 and 0x86 write the pull, direction and level words:
  - The byte at parameter 0 replaces the word with bits 15:8 cleared.
  - The byte at parameter 1 is ORed into bits 15:8 and ends the command.
  - Reads 0x87 and 0x88 return direction and level, low byte first.
- R10: Command 0x81 stores the configuration byte, clears status and pulses `fifo_flush` in that byte's cycle.
- R11: An unknown command code sets unknown-command (error bit 1), on a read or on a parameter write. Setting any error bit also sets status bit 3.
- R12: `key_push` sets status bit 0. `key_ovf` sets FIFO-overflow (error bit 6). `pwm_end[n]` sets status bit 5+n.
- R13: FIFO reads:
  - Read 0x89 returns 0 when the level is 1 or less. Otherwise it returns the entry at offset 1 and pulses `fifo_pop`.
  - Read 0x8A returns the entry at offset equal to the byte index, or 0 when the index is not below the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transaction start strobe |
| dir_wr | input | 1 | Direction with start: 1 write, 0 read |
| wr_valid | input | 1 | Write byte strobe |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte, valid in the rd_req cycle |
| irq_n | output | 1 | Active-low interrupt |
| key_push | input | 1 | Key event entered the FIFO |
| key_ovf | input | 1 | Key FIFO overflowed |
| pwm_end | input | NUM_PWM | PWM channel finished |
| fifo_level | input | FIFO_AW+1 | Entries held in the key FIFO |
| fifo_byte | input | 8 | FIFO entry at fifo_idx |
| fifo_idx | output | FIFO_AW | FIFO peek offset |
| fifo_pop | output | 1 | Drop one FIFO entry |
| fifo_flush | output | 1 | Empty the FIFO |
| cfg_byte | output | 8 | Configuration byte |
| clk_cfg | output | 8 | Clock setup |
| act_time | output | 8 | Active time |
| deb_time | output | 8 | Debounce time |
| key_size | output | 8 | Keypad geometry |
| gpio_pull | output | 16 | GPIO pull select |
| gpio_dir | output | 16 | GPIO direction |
| gpio_level | output | 16 | GPIO level |

## Verification
The bench uses the default parameters:
- `NUM_PWM` = 3 drives all three channel-end bits.
- `FIFO_AW` = 4 makes a full 16-entry level reachable for the peek boundary.
- `IDX_W` = 4 lets a long read run past every value's width into the zero region.

A behavioural model of status, error, command and index tracks every byte. `irq_n` is compared with the model on every clock. Each read byte and each FIFO strobe are compared in the cycle they occur.

// File: rtl/kpc_pkg.sv
package kpc_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OP_RD_ID    = 8'h80;
  localparam byte_t OP_WR_CFG   = 8'h81;
  localparam byte_t OP_RD_ST    = 8'h82;
  localparam byte_t OP_SOFT_RST = 8'h83;
  localparam byte_t OP_WR_PULL  = 8'h84;
  localparam byte_t OP_WR_DIR   = 8'h85;
  localparam byte_t OP_WR_LVL   = 8'h86;
  localparam byte_t OP_RD_DIR   = 8'h87;
  localparam byte_t OP_RD_LVL   = 8'h88;
  localparam byte_t OP_FIFO_POP = 8'h89;
  localparam byte_t OP_FIFO_PEEK= 8'h8A;
  localparam byte_t OP_WR_ACT   = 8'h8B;
  localparam byte_t OP_RD_ERR   = 8'h8C;
  localparam byte_t OP_RD_ROT   = 8'h8E;
  localparam byte_t OP_WR_DEB   = 8'h8F;
  localparam byte_t OP_WR_KSZ   = 8'h90;
  localparam byte_t OP_RD_KSZ   = 8'h91;
  localparam byte_t OP_RD_CFG   = 8'h92;
  localparam byte_t OP_WR_CLK   = 8'h93;
  localparam byte_t OP_RD_CLK   = 8'h94;
  localparam byte_t OP_IDLE     = 8'hFF;

  localparam byte_t RV_CFG = 8'h80;
  localparam byte_t RV_ST  = 8'h10;
  localparam byte_t RV_ACT = 8'd125;
  localparam byte_t RV_DEB = 8'd3;
  localparam byte_t RV_KSZ = 8'h33;
  localparam byte_t RV_CLK = 8'h08;

  localparam logic [15:0] DEV_ID     = 16'h0400;
  localparam byte_t       UNLOCK_KEY = 8'hAA;

  localparam int GPIO_W    = 16;
  localparam int KP_MIN    = 3;
  localparam int KP_LO_MAX = 12;
  localparam int KP_HI_MAX = 8;

  localparam int ST_KEY    = 0;
  localparam int ST_ERR    = 3;
  localparam int ST_NOINIT = 4;
  localparam int ST_PWM0   = 5;

  localparam int ER_BADP = 0;
  localparam int ER_UNKN = 1;
  localparam int ER_FOVR = 6;

  function automatic byte_t pick16(input logic [15:0] v, input int i);
    if (i == 0)      return v[7:0];
    else if (i == 1) return v[15:8];
    else             return 8'h00;
  endfunction

  function automatic byte_t pick8(input byte_t v, input int i);
    return (i == 0) ? v : 8'h00;
  endfunction
endpackage

// File: rtl/kpc_seq.sv
module kpc_seq
  import kpc_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_wr,
  input  logic             wr_valid,
  input  byte_t            wr_data,
  input  logic             rd_req,
  input  logic             cmd_done,
  output byte_t            cmd_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] par_idx,
  output logic             wr_go,
  output logic             par_go,
  output logic             rd_go
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             dir_q, dir_d;
  logic [IDX_W-1:0] idx_d;
  byte_t            cmd_d;

  assign wr_go   = wr_valid & dir_q & ~start;
  assign rd_go   = rd_req & ~dir_q & ~start;
  assign par_go  = wr_go & (idx_q != '0);
  assign par_idx = idx_q - 1'b1;

  always_comb begin
    dir_d = dir_q;
    idx_d = idx_q;
    cmd_d = cmd_q;
    if (start) begin
      dir_d = dir_wr;
      idx_d = '0;
    end else if (wr_go || rd_go) begin
      if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
    end
    if (wr_go) begin
      if (idx_q == '0)   cmd_d = wr_data;
      else if (cmd_done) cmd_d = OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      idx_q <= '0;
      cmd_q <= OP_IDLE;
    end else begin
      dir_q <= dir_d;
      idx_q <= idx_d;
      cmd_q <= cmd_d;
    end
  end

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (idx_q == '0));

  p_idle_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_go && cmd_done) |=> (cmd_q == OP_IDLE));
endmodule

// File: rtl/kpc_regs.sv
module kpc_regs
  import kpc_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int NUM_PWM = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  byte_t             cmd,
  input  logic              par_go,
  input  logic [IDX_W-1:0]  par_idx,
  input  byte_t             wr_data,
  input  logic              rd_go,
  input  logic              rd_unknown,
  input  logic              rd_st_clr,
  input  logic              key_push,
  input  logic              key_ovf,
  input  logic [NUM_PWM-1:0] pwm_end,
  output logic              cmd_done,
  output logic              fifo_flush,
  output byte_t             st_q,
  output byte_t             err_q,
  output byte_t             cfg_q,
  output byte_t             clk_q,
  output byte_t             act_q,
  output byte_t             deb_q,
  output byte_t             ksz_q,
  output logic [GPIO_W-1:0] pull_q,
  output logic [GPIO_W-1:0] dir_q,
  output logic [GPIO_W-1:0] lvl_q
);
  localparam int HALF = GPIO_W / 2;

  byte_t st_d, err_d, cfg_d, clk_d, act_d, deb_d, ksz_d, err_set, st_base;
  logic [GPIO_W-1:0] pull_d, dir_d, lvl_d;
  logic soft_rst, st_wipe, first_par;

  assign first_par = (par_idx == '0);

  function automatic logic [GPIO_W-1:0] gpio_next(input logic [GPIO_W-1:0] cur,
                                                  input logic first,
                                                  input byte_t v);
    logic [GPIO_W-1:0] r;
    if (first) r = {{(GPIO_W-8){1'b0}}, v};
    else       r = cur | ({{(GPIO_W-8){1'b0}}, v} << HALF);
    return r;
  endfunction

  always_comb begin
    cfg_d = cfg_q; clk_d = clk_q; act_d = act_q; deb_d = deb_q; ksz_d = ksz_q;
    pull_d = pull_q; dir_d = dir_q; lvl_d = lvl_q;
    err_set = '0; cmd_done = 1'b0; fifo_flush = 1'b0;
    soft_rst = 1'b0; st_wipe = 1'b0;
    if (par_go) begin
      case (cmd)
        OP_WR_CFG: begin
          cfg_d = wr_data; st_wipe = 1'b1; fifo_flush = 1'b1; cmd_done = 1'b1;
        end
        OP_SOFT_RST: begin
          cmd_done = 1'b1;
          if (wr_data == UNLOCK_KEY) soft_rst = 1'b1;
          else                       err_set[ER_BADP] = 1'b1;
        end
        OP_WR_PULL: begin
          pull_d = gpio_next(pull_q, first_par, wr_data); cmd_done = ~first_par;
        end
        OP_WR_DIR: begin
          dir_d = gpio_next(dir_q, first_par, wr_data); cmd_done = ~first_par;
        end
        OP_WR_LVL: begin
          lvl_d = gpio_next(lvl_q, first_par, wr_data); cmd_done = ~first_par;
        end
        OP_WR_ACT: begin
          act_d = wr_data; cmd_done = 1'b1;
        end
        OP_WR_DEB: begin
          deb_d = wr_data; cmd_done = 1'b1;
          if (wr_data == 8'h00) err_set[ER_BADP] = 1'b1;
        end
        OP_WR_KSZ: begin
          ksz_d = wr_data; cmd_done = 1'b1;
          if (int'(wr_data[3:0]) < KP_MIN || int'(wr_data[3:0]) > KP_LO_MAX ||
              int'(wr_data[7:4]) < KP_MIN || int'(wr_data[7:4]) > KP_HI_MAX)
            err_set[ER_BADP] = 1'b1;
        end
        OP_WR_CLK: begin
          clk_d = wr_data; cmd_done = 1'b1;
          if (wr_data[1] ^ wr_data[0]) err_set[ER_BADP] = 1'b1;
        end
        OP_IDLE: err_set[ER_BADP] = 1'b1;
        default: err_set[ER_UNKN] = 1'b1;
      endcase
    end
    if (rd_unknown) err_set[ER_UNKN] = 1'b1;
    if (key_ovf)    err_set[ER_FOVR] = 1'b1;

    st_base = st_q;
    if (st_wipe || rd_st_clr) st_base = '0;
    if (soft_rst) begin
      st_base = RV_ST;
      cfg_d = RV_CFG; clk_d = RV_CLK; act_d = RV_ACT; deb_d = RV_DEB; ksz_d = RV_KSZ;
    end
    st_d = st_base | (8'(pwm_end) << ST_PWM0);
    if (key_push)   st_d[ST_KEY] = 1'b1;
    if (|err_set)   st_d[ST_ERR] = 1'b1;
    err_d = err_q | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RV_ST; err_q <= '0; cfg_q <= RV_CFG; clk_q <= RV_CLK;
      act_q <= RV_ACT; deb_q <= RV_DEB; ksz_q <= RV_KSZ;
      pull_q <= '0; dir_q <= '0; lvl_q <= '0;
    end else begin
      st_q <= st_d; err_q <= err_d; cfg_q <= cfg_d; clk_q <= clk_d;
      act_q <= act_d; deb_q <= deb_d; ksz_q <= ksz_d;
      pull_q <= pull_d; dir_q <= dir_d; lvl_q <= lvl_d;
    end
  end

  p_err_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & $past(err_q)) == $past(err_q)));

  p_err_flags_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_q & ~$past(err_q)) != 8'h00) |-> st_q[ST_ERR]);

  p_noinit_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && cmd == OP_RD_ST && st_q[ST_NOINIT]) |=> st_q[ST_NOINIT]);

  p_pwm_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|pwm_end) |=> (st_q[ST_PWM0 +: NUM_PWM] != '0));
endmodule

// File: rtl/kpc_rdmux.sv
module kpc_rdmux
  import kpc_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int FIFO_AW = 4
) (
  input  byte_t              cmd,
  input  logic [IDX_W-1:0]   idx,
  input  logic               rd_go,
  input  byte_t              st,
  input  byte_t              err,
  input  byte_t              cfg,
  input  byte_t              clk_cfg,
  input  byte_t              ksz,
  input  logic [GPIO_W-1:0]  dir,
  input  logic [GPIO_W-1:0]  lvl,
  input  logic [FIFO_AW:0]   fifo_level,
  input  byte_t              fifo_byte,
  output byte_t              rd_data,
  output logic               rd_unknown,
  output logic               rd_st_clr,
  output logic               fifo_pop,
  output logic [FIFO_AW-1:0] fifo_idx
);
  int i;
  assign i = int'(idx);

  always_comb begin
    rd_data = 8'h00; rd_unknown = 1'b0; rd_st_clr = 1'b0;
    fifo_pop = 1'b0; fifo_idx = '0;
    case (cmd)
      OP_RD_ID:  rd_data = pick16(DEV_ID, i);
      OP_RD_ST: begin
        rd_data   = pick8(st, i);
        rd_st_clr = rd_go & ~st[ST_NOINIT];
      end
      OP_RD_DIR: rd_data = pick16(dir, i);
      OP_RD_LVL: rd_data = pick16(lvl, i);
      OP_FIFO_POP: begin
        if (int'(fifo_level) > 1) begin
          fifo_idx = FIFO_AW'(1);
          rd_data  = fifo_byte;
          fifo_pop = rd_go;
        end
      end
      OP_FIFO_PEEK: begin
        if (i < int'(fifo_level)) begin
          fifo_idx = FIFO_AW'(idx);
          rd_data  = fifo_byte;
        end
      end
      OP_RD_ERR: rd_data = pick8(err, i);
      OP_RD_ROT: rd_data = 8'h00;
      OP_RD_KSZ: rd_data = pick8(ksz, i);
      OP_RD_CFG: rd_data = pick8({4'h0, cfg[3:0]}, i);
      OP_RD_CLK: rd_data = pick8({clk_cfg[7:2], 2'b10}, i);
      default:   rd_unknown = rd_go;
    endcase
  end
endmodule

// File: rtl/kpc_cmd_regs.sv
module kpc_cmd_regs
  import kpc_pkg::*;
#(
  parameter int NUM_PWM = 3,
  parameter int FIFO_AW = 4,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir_wr,
  input  logic               wr_valid,
  input  logic [7:0]         wr_data,
  input  logic               rd_req,
  output logic [7:0]         rd_data,
  output logic               irq_n,
  input  logic               key_push,
  input  logic               key_ovf,
  input  logic [NUM_PWM-1:0] pwm_end,
  input  logic [FIFO_AW:0]   fifo_level,
  input  logic [7:0]         fifo_byte,
  output logic [FIFO_AW-1:0] fifo_idx,
  output logic               fifo_pop,
  output logic               fifo_flush,
  output logic [7:0]         cfg_byte,
  output logic [7:0]         clk_cfg,
  output logic [7:0]         act_time,
  output logic [7:0]         deb_time,
  output logic [7:0]         key_size,
  output logic [15:0]        gpio_pull,
  output logic [15:0]        gpio_dir,
  output logic [15:0]        gpio_level
);
  byte_t            cmd_q, st_q, err_q;
  logic [IDX_W-1:0] idx_q, par_idx;
  logic             wr_go, par_go, rd_go, cmd_done, rd_unknown, rd_st_clr;

  kpc_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .cmd_done(cmd_done), .cmd_q(cmd_q), .idx_q(idx_q), .par_idx(par_idx),
    .wr_go(wr_go), .par_go(par_go), .rd_go(rd_go)
  );

  kpc_regs #(.IDX_W(IDX_W), .NUM_PWM(NUM_PWM)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_q), .par_go(par_go), .par_idx(par_idx),
    .wr_data(wr_data), .rd_go(rd_go), .rd_unknown(rd_unknown),
    .rd_st_clr(rd_st_clr), .key_push(key_push), .key_ovf(key_ovf),
    .pwm_end(pwm_end), .cmd_done(cmd_done), .fifo_flush(fifo_flush),
    .st_q(st_q), .err_q(err_q), .cfg_q(cfg_byte), .clk_q(clk_cfg),
    .act_q(act_time), .deb_q(deb_time), .ksz_q(key_size),
    .pull_q(gpio_pull), .dir_q(gpio_dir), .lvl_q(gpio_level)
  );

  kpc_rdmux #(.IDX_W(IDX_W), .FIFO_AW(FIFO_AW)) u_rdmux (
    .cmd(cmd_q), .idx(idx_q), .rd_go(rd_go), .st(st_q), .err(err_q),
    .cfg(cfg_byte), .clk_cfg(clk_cfg), .ksz(key_size), .dir(gpio_dir),
    .lvl(gpio_level), .fifo_level(fifo_level), .fifo_byte(fifo_byte),
    .rd_data(rd_data), .rd_unknown(rd_unknown), .rd_st_clr(rd_st_clr),
    .fifo_pop(fifo_pop), .fifo_idx(fifo_idx)
  );

  assign irq_n = ~(|st_q);

  p_key_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |=> !irq_n);

  p_wr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !wr_go && !rd_go) |=> $stable(idx_q));

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush && !key_push && !key_ovf && pwm_end == '0) |=> irq_n);
endmodule

// File: tb/sim_kpc_cmd_regs.sv
module sim_kpc_cmd_regs;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, start, dir_wr, wr_valid, rd_req, key_push, key_ovf;
  logic [7:0] wr_data, rd_data, fifo_byte;
  logic [2:0] pwm_end;
  logic [4:0] fifo_level;
  logic [3:0] fifo_idx;
  logic irq_n, fifo_pop, fifo_flush;
  logic [7:0] cfg_byte, clk_cfg, act_time, deb_time, key_size;
  logic [15:0] gpio_pull, gpio_dir, gpio_level;

  always #(CLK_P/2) clk = ~clk;
  assign fifo_byte = {4'hA, fifo_idx};

  kpc_cmd_regs u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .irq_n(irq_n), .key_push(key_push), .key_ovf(key_ovf),
    .pwm_end(pwm_end), .fifo_level(fifo_level), .fifo_byte(fifo_byte),
    .fifo_idx(fifo_idx), .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
    .cfg_byte(cfg_byte), .clk_cfg(clk_cfg), .act_time(act_time),
    .deb_time(deb_time), .key_size(key_size), .gpio_pull(gpio_pull),
    .gpio_dir(gpio_dir), .gpio_level(gpio_level)
  );

  int tests = 0, fails = 0;
  logic [7:0] m_cmd, m_st, m_err, m_cfg, m_clk, m_act, m_deb, m_ksz;
  logic [15:0] m_pull, m_dir, m_lvl;
  int m_idx;
  logic m_dirw;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_irq();
    chk("R3 irq_n", {31'd0, irq_n}, {31'd0, (m_st == 8'h00)});
  endtask

  task automatic chk_regs(input string req);
    chk(req, {cfg_byte, clk_cfg, act_time, deb_time}, {m_cfg, m_clk, m_act, m_deb});
    chk(req, {24'd0, key_size}, {24'd0, m_ksz});
    chk(req, {gpio_pull, gpio_dir}, {m_pull, m_dir});
    chk(req, {16'd0, gpio_level}, {16'd0, m_lvl});
  endtask

  task automatic m_error(input int b);
    m_err[b] = 1'b1;
    m_st[3]  = 1'b1;
  endtask

  task automatic m_soft();
    m_cfg = 8'h80; m_st = 8'h10; m_act = 8'd125; m_deb = 8'd3;
    m_ksz = 8'h33; m_clk = 8'h08;
  endtask

  task automatic start_tx(input logic w);
    start = 1'b1; dir_wr = w;
    m_idx = 0; m_dirw = w;
    @(negedge clk);
    start = 1'b0;
    chk_irq();
  endtask

  task automatic wr_byte(input logic [7:0] b);
    logic first, done, exp_flush;
    wr_valid = 1'b1; wr_data = b;
    exp_flush = m_dirw && m_idx > 0 && m_cmd == 8'h81;
    #1;
    chk("R10 flush", {31'd0, fifo_flush}, {31'd0, exp_flush});
    if (m_dirw) begin
      if (m_idx == 0) m_cmd = b;
      else begin
        first = (m_idx == 1);
        done = 1'b1;
        case (m_cmd)
          8'h81: begin m_cfg = b; m_st = 8'h00; end
          8'h83: if (b == 8'hAA) m_soft(); else m_error(0);
          8'h84: begin if (first) m_pull = {8'h00, b}; else m_pull[15:8] |= b; done = !first; end
          8'h85: begin if (first) m_dir = {8'h00, b}; else m_dir[15:8] |= b; done = !first; end
          8'h86: begin if (first) m_lvl = {8'h00, b}; else m_lvl[15:8] |= b; done = !first; end
          8'h8B: m_act = b;
          8'h8F: begin m_deb = b; if (b == 0) m_error(0); end
          8'h90: begin
            m_ksz = b;
            if (b[3:0] < 3 || b[3:0] > 12 || b[7:4] < 3 || b[7:4] > 8) m_error(0);
          end
          8'h93: begin m_clk = b; if (b[1] != b[0]) m_error(0); end
          8'hFF: begin m_error(0); done = 1'b0; end
          default: begin m_error(1); done = 1'b0; end
        endcase
        if (done) m_cmd = 8'hFF;
      end
      if (m_idx < 15) m_idx++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
    chk_irq();
  endtask

  task automatic rd_byte(input string req);
    logic [7:0] e;
    logic ep;
    rd_req = 1'b1;
    e = 8'h00; ep = 1'b0;
    #1;
    if (!m_dirw) begin
      case (m_cmd)
        8'h80: e = (m_idx == 1) ? 8'h04 : 8'h00;
        8'h82: begin e = (m_idx == 0) ? m_st : 8'h00; if (!m_st[4]) m_st = 8'h00; end
        8'h87: e = (m_idx == 0) ? m_dir[7:0] : (m_idx == 1) ? m_dir[15:8] : 8'h00;
        8'h88: e = (m_idx == 0) ? m_lvl[7:0] : (m_idx == 1) ? m_lvl[15:8] : 8'h00;
        8'h89: if (fifo_level > 1) begin e = 8'hA1; ep = 1'b1; end
        8'h8A: if (m_idx < int'(fifo_level)) e = 8'hA0 + 8'(m_idx);
        8'h8C: e = (m_idx == 0) ? m_err : 8'h00;
        8'h8E: e = 8'h00;
        8'h91: e = (m_idx == 0) ? m_ksz : 8'h00;
        8'h92: e = (m_idx == 0) ? {4'h0, m_cfg[3:0]} : 8'h00;
        8'h94: e = (m_idx == 0) ? {m_clk[7:2], 2'b10} : 8'h00;
        default: m_error(1);
      endcase
      chk(req, {24'd0, rd_data}, {24'd0, e});
      chk("R13 pop", {31'd0, fifo_pop}, {31'd0, ep});
      if (m_idx < 15) m_idx++;
    end
    @(negedge clk);
    rd_req = 1'b0;
    chk_irq();
  endtask

  task automatic cmd1(input logic [7:0] c, input logic [7:0] p);
    start_tx(1'b1); wr_byte(c); wr_byte(p);
  endtask

  task automatic sel_rd(input logic [7:0] c);
    start_tx(1'b1); wr_byte(c); start_tx(1'b0);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; dir_wr = 0; wr_valid = 0; rd_req = 0;
    wr_data = 0; key_push = 0; key_ovf = 0; pwm_end = 0; fifo_level = 0;
    m_cmd = 8'hFF; m_err = 0; m_pull = 0; m_dir = 0; m_lvl = 0;
    m_idx = 0; m_dirw = 0; m_soft();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_regs("R1 reset regs"); chk_irq();

    // R6 id, beyond width zero
    sel_rd(8'h80); rd_byte("R6 id lo"); rd_byte("R6 id hi"); rd_byte("R6 id past");
    // R5 status kept while not-initialised
    sel_rd(8'h82); rd_byte("R5 st noinit"); rd_byte("R5 st past");
    sel_rd(8'h82); rd_byte("R5 st still set");
    // R10 config write clears status
    start_tx(1'b1); wr_byte(8'h81); wr_byte(8'h35);
    chk_regs("R10 cfg");
    // R4 extra byte after finished command
    wr_byte(8'h12);
    chk_regs("R4 unchanged");
    sel_rd(8'h8C); rd_byte("R4 err badp");
    sel_rd(8'h82); rd_byte("R5 st err"); sel_rd(8'h82); rd_byte("R5 st cleared");
    sel_rd(8'h92); rd_byte("R6 cfg nibble");
    // R8 parameter checks
    cmd1(8'h90, 8'h48); cmd1(8'h90, 8'h2D); cmd1(8'h90, 8'h9C); cmd1(8'h90, 8'h3D);
    cmd1(8'h8F, 8'h00); cmd1(8'h8F, 8'h07); cmd1(8'h8B, 8'h40);
    cmd1(8'h93, 8'h01); cmd1(8'h93, 8'h02); cmd1(8'h93, 8'hA7);
    chk_regs("R8 stored");
    sel_rd(8'h91); rd_byte("R6 ksz");
    sel_rd(8'h94); rd_byte("R6 clock fmt");
    sel_rd(8'h8E); rd_byte("R6 rotator");
    // R9 gpio words
    start_tx(1'b1); wr_byte(8'h85); wr_byte(8'h34); wr_byte(8'h12);
    start_tx(1'b1); wr_byte(8'h86); wr_byte(8'hCD); wr_byte(8'hAB);
    start_tx(1'b1); wr_byte(8'h84); wr_byte(8'h77);
    chk_regs("R9 gpio");
    start_tx(1'b1); wr_byte(8'h84); wr_byte(8'h01); wr_byte(8'h80);
    chk_regs("R9 pull hi");
    sel_rd(8'h87); rd_byte("R9 dir lo"); rd_byte("R9 dir hi"); rd_byte("R9 dir past");
    sel_rd(8'h88); rd_byte("R9 lvl lo"); rd_byte("R9 lvl hi");
    // R2 wrong direction ignored
    sel_rd(8'h91); wr_valid = 1; wr_data = 8'h80; @(negedge clk); wr_valid = 0;
    rd_byte("R2 ignored write");
    start_tx(1'b1); rd_req = 1; @(negedge clk); rd_req = 0;
    wr_byte(8'h8B); wr_byte(8'h22);
    chk_regs("R2 read in write ignored");
    // R11 unknown commands
    sel_rd(8'h82); rd_byte("R11 clear st");
    cmd1(8'h99, 8'h00);
    sel_rd(8'h77); rd_byte("R11 unknown read");
    sel_rd(8'h8C); rd_byte("R11 err unkn");
    // R7 soft reset
    cmd1(8'h83, 8'h55);
    cmd1(8'h83, 8'hAA);
    chk_regs("R7 soft reset");
    sel_rd(8'h8C); rd_byte("R7 err kept");
    sel_rd(8'h82); rd_byte("R7 status noinit");
    // R12 events
    cmd1(8'h81, 8'h00);
    key_push = 1; m_st[0] = 1; @(negedge clk); key_push = 0; chk_irq();
    sel_rd(8'h82); rd_byte("R12 key bit");
    pwm_end = 3'b101; m_st[5] = 1; m_st[7] = 1; @(negedge clk); pwm_end = 0; chk_irq();
    sel_rd(8'h82); rd_byte("R12 pwm bits");
    key_ovf = 1; m_error(6); @(negedge clk); key_ovf = 0; chk_irq();
    sel_rd(8'h8C); rd_byte("R12 ovf err");
    sel_rd(8'h82); rd_byte("R12 st err");
    // R13 fifo
    fifo_level = 5'd3;
    sel_rd(8'h8A);
    for (int k = 0; k < 4; k++) rd_byte("R13 peek");
    sel_rd(8'h89); rd_byte("R13 pop");
    fifo_level = 5'd1;
    sel_rd(8'h89); rd_byte("R13 pop empty");
    fifo_level = 5'd16;
    sel_rd(8'h8A);
    for (int k = 0; k < 17; k++) rd_byte("R13 peek full");
    // R10 flush strobe only on config parameter
    cmd1(8'h81, 8'h0F);
    chk_regs("R10 cfg2");
    chk_irq();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule